// File: doc/BRIEF.md
# Asynchronous Memory Cycle Timing Generator

This block is the host-side engine that runs one access to an external asynchronous memory or memory-mapped device. When it accepts a request, it takes a snapshot of the timing configuration and starts a single tick counter. Every strobe edge is a separately programmed tick on that counter. The strobes are chip select, address latch, read enable and write enable, all active low. For each strobe, the register holds an on-tick and an off-tick. Chip select and address latch also have separate off-ticks for reads and writes.

Reads and writes each have their own total length. A read captures the bus at a programmed sample tick. On a multiplexed address/data bus, the block puts the device address on the bus first. For a write it switches to data at a programmed tick. For a read it releases the bus when the read off-tick of the address latch is reached. After the access, an optional idle gap keeps the bus quiet. This gap is a cycle-to-cycle delay, plus a turnaround time after reads.

The device width is 8 or 16 bits. In 16-bit mode the byte address from the host is turned into a word address. The host sees `busy` and a one-clock `done` pulse, and reads the captured data on `rd_data`.

Top module: `amc_cycle_gen`

## Requirements
- R1: Tick 0 is the first clock cycle after a request is accepted. `rd_n` is low exactly on the ticks t with t_rd_on <= t < t_rd_off, and only during reads. `wr_n` is low exactly on the ticks with t_wr_on <= t < t_wr_off, and only during writes. `rd_n` and `wr_n` are never low together.
- R2: `sel_n` is low on ticks t_sel_on <= t < off. `alat_n` is low on ticks t_alat_on <= t < off. For each of the two strobes, off is its read off-tick on a read and its write off-tick on a write.
- R3: An access lasts L active ticks, where L is t_len_rd for reads and t_len_wr for writes. A length of 0 behaves as 1. `busy` is high from tick 0 until `done`. `done` is a single-clock pulse. With no gap, `done` comes in the cycle after the last active tick, and `busy` is low in that cycle.
- R4: After the active ticks, the block inserts t_c2c idle cycles, plus t_turn more after a read. During these cycles all strobes are high, the bus is not driven, and `busy` stays high. `done` follows the last idle cycle. A zero gap inserts nothing.
- R5: During a read, `bus_in` is captured into `rd_data` at the clock edge that ends tick t_sample. In 8-bit mode only bits [7:0] are kept and the upper bits read 0. If t_sample >= L, `rd_data` keeps its previous value. Writes never change `rd_data`.
- R6: With `mode_mux`=1, the bus (`bus_oe`=1) carries the zero-extended device address while tick < t_wdata on writes, or while tick < t_alat_off_rd on reads. After that, a write drives data and a read releases the bus (`bus_oe`=0, `bus_out`=0).
- R7: With `mode_mux`=0, a write drives its data on the bus for the whole access, and a read leaves the bus released.
- R8: During an access, `dev_addr` is req_addr>>1 in 16-bit mode (`mode_x16`=1) and req_addr in 8-bit mode. When no access is active, `dev_addr` and `bus_out` are 0. In 8-bit mode, write data is driven with bits above [7:0] set to 0.
- R9: A request is accepted only while `busy` is low. Requests made during an access or a gap are ignored.
- R10: Timing, mode, address and data are sampled when the request is accepted. Changes during an access take effect only on the next access.
- R11: In reset and after reset, all strobes are high, `busy`, `done` and `bus_oe` are low, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | DATA_W | Write data |
| t_sel_on | input | TW | Chip-select on tick |
| t_sel_off_rd | input | TW | Chip-select off tick, reads |
| t_sel_off_wr | input | TW | Chip-select off tick, writes |
| t_alat_on | input | TW | Address-latch on tick |
| t_alat_off_rd | input | TW | Address-latch off tick, reads (also ends the mux address phase on reads) |
| t_alat_off_wr | input | TW | Address-latch off tick, writes |
| t_rd_on | input | TW | Read-enable on tick |
| t_rd_off | input | TW | Read-enable off tick |
| t_wr_on | input | TW | Write-enable on tick |
| t_wr_off | input | TW | Write-enable off tick |
| t_len_rd | input | TW | Read access length in ticks |
| t_len_wr | input | TW | Write access length in ticks |
| t_sample | input | TW | Read sample tick |
| t_wdata | input | TW | Multiplexed-bus switch to write data |
| t_turn | input | TW | Turnaround gap after reads |
| t_c2c | input | TW | Gap after every access |
| mode_mux | input | 1 | 1 = multiplexed address/data bus |
| mode_x16 | input | 1 | 1 = 16-bit device, 0 = 8-bit |
| bus_in | input | DATA_W | Data bus as seen from the device |
| busy | output | 1 | Access or gap in progress |
| done | output | 1 | One-clock end-of-access pulse |
| sel_n | output | 1 | Chip select, active low |
| alat_n | output | 1 | Address latch, active low |
| rd_n | output | 1 | Read enable, active low |
| wr_n | output | 1 | Write enable, active low |
| dev_addr | output | ADDR_W | Device address lines |
| bus_out | output | DATA_W | Bus drive value |
| bus_oe | output | 1 | Bus drive enable |
| rd_data | output | DATA_W | Captured read data |

## Verification
The bench builds the block with TW=4, ADDR_W=8 and DATA_W=16. A 4-bit tick field keeps every setting small enough to sweep in full. It covers every on/off pair of each strobe in a 7-tick access, every sample tick including those past the end, every switch tick of the multiplexed bus, and every mix of turnaround and cycle-to-cycle gap up to 3. The widths of 8 and 16 bits make both address mappings and the upper-byte zeroing visible at the ports. The bench also holds requests during busy periods and scrambles the configuration in the middle of an access.

// File: rtl/amc_pkg.sv
// Shared types for the asynchronous memory cycle generator.
// Assumes: strobe indices are fixed as listed; the top orders its strobe
// arrays the same way.
package amc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } amc_state_e;

    localparam int NUM_STROBES = 4;
    localparam int STB_SEL  = 0;
    localparam int STB_ALAT = 1;
    localparam int STB_RD   = 2;
    localparam int STB_WR   = 3;
endpackage

// File: rtl/amc_strobe_win.sv
// One strobe window: active while enabled and on <= tick < off.
// Assumes: tick, on and off share the same width; off <= on gives no window.
module amc_strobe_win #(
    parameter int TW = 5
) (
    input  logic          en,
    input  logic [TW-1:0] tick,
    input  logic [TW-1:0] t_on,
    input  logic [TW-1:0] t_off,
    output logic          act
);
    // window compare against the shared tick counter
    assign act = en && (tick >= t_on) && (tick < t_off);
endmodule

// File: rtl/amc_sequencer.sv
// Cycle sequencer: idle -> active ticks -> optional idle gap -> done.
// Assumes: len and gap are stable from the cycle after start (snapshot in top);
// a length of zero ends after one tick.
module amc_sequencer
    import amc_pkg::*;
#(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] len,
    input  logic [TW:0]   gap,
    output amc_state_e    state,
    output logic [TW-1:0] tick,
    output logic          done
);
    localparam logic [TW:0]   ONE_W = (TW+1)'(1);
    localparam logic [TW-1:0] ONE_T = TW'(1);

    logic [TW:0] gcnt;
    logic        last_tick;

    // last active tick reached when tick+1 >= len (len 0 acts as 1)
    assign last_tick = ({1'b0, tick} + ONE_W) >= {1'b0, len};

    // state, tick counter, gap counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tick  <= '0;
            gcnt  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ACTIVE;
                        tick  <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (last_tick) begin
                        tick <= '0;
                        gcnt <= '0;
                        if (gap == '0) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_GAP;
                        end
                    end else begin
                        tick <= tick + ONE_T;
                    end
                end
                ST_GAP: begin
                    if (gcnt == gap - ONE_W) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        gcnt <= gcnt + ONE_W;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: done lasts exactly one clock
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: tick never passes the snapshot length (zero length gives tick 0 only)
    assert_tick_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |-> ((tick < len) || (tick == '0)));

    // R4: a gap is entered only when one was requested
    assert_gap_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (gap != '0));

    // R9: a start outside idle never restarts the counter
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ACTIVE) && !last_tick) |=> ((state == ST_ACTIVE) && (tick == $past(tick) + ONE_T)));
endmodule

// File: rtl/amc_bus_path.sv
// Bus datapath: selects address or write data for the shared bus and
// captures read data at the sample tick.
// Assumes: ADDR_W <= DATA_W; DATA_W is even (8-bit mode keeps the low half).
module amc_bus_path #(
    parameter int TW     = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              is_wr,
    input  logic              mux,
    input  logic              x16,
    input  logic [TW-1:0]     tick,
    input  logic [TW-1:0]     t_addr_end_rd,
    input  logic [TW-1:0]     t_wdata,
    input  logic [TW-1:0]     t_sample,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] addr_bus;
    logic [DATA_W-1:0] wdata_fit;
    logic [DATA_W-1:0] rdata_fit;
    logic              addr_phase;

    // zero-extend the device address onto the bus width
    always_comb begin
        addr_bus = '0;
        addr_bus[ADDR_W-1:0] = addr;
    end

    // narrow the write data and the captured data in 8-bit mode
    assign wdata_fit = x16 ? wdata  : {{(DATA_W-HALF){1'b0}}, wdata[HALF-1:0]};
    assign rdata_fit = x16 ? bus_in : {{(DATA_W-HALF){1'b0}}, bus_in[HALF-1:0]};

    // multiplexed address phase ends at the write-data or read-release tick
    assign addr_phase = mux && (is_wr ? (tick < t_wdata) : (tick < t_addr_end_rd));

    // bus drive selection
    always_comb begin
        bus_oe  = 1'b0;
        bus_out = '0;
        if (active) begin
            if (addr_phase) begin
                bus_oe  = 1'b1;
                bus_out = addr_bus;
            end else if (is_wr) begin
                bus_oe  = 1'b1;
                bus_out = wdata_fit;
            end
        end
    end

    // read capture at the edge that ends the sample tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (active && !is_wr && (tick == t_sample)) begin
            rd_data <= rdata_fit;
        end
    end

    // R5: read data changes only after a cycle of an active read
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(active && !is_wr));

    // R7: the bus is never driven during a non-multiplexed read
    assert_nonmux_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !mux && !is_wr) |-> !bus_oe);
endmodule

// File: rtl/amc_cycle_gen.sv
// Asynchronous memory cycle timing generator (top).
// Accepts one request while idle, snapshots timing and request, then runs
// strobes, bus drive and read capture from a single tick counter.
// Assumes: ADDR_W <= DATA_W; configuration ports may change at any time.
module amc_cycle_gen
    import amc_pkg::*;
#(
    parameter int TW     = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TW-1:0]     t_sel_on,
    input  logic [TW-1:0]     t_sel_off_rd,
    input  logic [TW-1:0]     t_sel_off_wr,
    input  logic [TW-1:0]     t_alat_on,
    input  logic [TW-1:0]     t_alat_off_rd,
    input  logic [TW-1:0]     t_alat_off_wr,
    input  logic [TW-1:0]     t_rd_on,
    input  logic [TW-1:0]     t_rd_off,
    input  logic [TW-1:0]     t_wr_on,
    input  logic [TW-1:0]     t_wr_off,
    input  logic [TW-1:0]     t_len_rd,
    input  logic [TW-1:0]     t_len_wr,
    input  logic [TW-1:0]     t_sample,
    input  logic [TW-1:0]     t_wdata,
    input  logic [TW-1:0]     t_turn,
    input  logic [TW-1:0]     t_c2c,
    input  logic              mode_mux,
    input  logic              mode_x16,
    input  logic [DATA_W-1:0] bus_in,
    output logic              busy,
    output logic              done,
    output logic              sel_n,
    output logic              alat_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data
);
    amc_state_e        state;
    logic [TW-1:0]     tick;
    logic              start;
    logic              active;

    logic              wr_q, mux_q, x16_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TW-1:0]     sel_on_q, sel_off_q, alat_on_q, alat_off_q, alat_off_rd_q;
    logic [TW-1:0]     rd_on_q, rd_off_q, wr_on_q, wr_off_q;
    logic [TW-1:0]     len_q, sample_q, wdat_q;
    logic [TW:0]       gap_q;

    logic [TW-1:0]     on_v  [NUM_STROBES];
    logic [TW-1:0]     off_v [NUM_STROBES];
    logic              en_v  [NUM_STROBES];
    logic              act_v [NUM_STROBES];

    assign start  = req_valid && (state == ST_IDLE);
    assign active = (state == ST_ACTIVE);
    assign busy   = (state != ST_IDLE);

    // snapshot of request and configuration at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0; mux_q <= 1'b0; x16_q <= 1'b0;
            addr_q <= '0; wdata_q <= '0;
            sel_on_q <= '0; sel_off_q <= '0; alat_on_q <= '0; alat_off_q <= '0;
            alat_off_rd_q <= '0;
            rd_on_q <= '0; rd_off_q <= '0; wr_on_q <= '0; wr_off_q <= '0;
            len_q <= '0; sample_q <= '0; wdat_q <= '0; gap_q <= '0;
        end else if (start) begin
            wr_q          <= req_write;
            mux_q         <= mode_mux;
            x16_q         <= mode_x16;
            addr_q        <= mode_x16 ? (req_addr >> 1) : req_addr;
            wdata_q       <= req_wdata;
            sel_on_q      <= t_sel_on;
            sel_off_q     <= req_write ? t_sel_off_wr : t_sel_off_rd;
            alat_on_q     <= t_alat_on;
            alat_off_q    <= req_write ? t_alat_off_wr : t_alat_off_rd;
            alat_off_rd_q <= t_alat_off_rd;
            rd_on_q       <= t_rd_on;
            rd_off_q      <= t_rd_off;
            wr_on_q       <= t_wr_on;
            wr_off_q      <= t_wr_off;
            len_q         <= req_write ? t_len_wr : t_len_rd;
            sample_q      <= t_sample;
            wdat_q        <= t_wdata;
            gap_q         <= {1'b0, t_c2c} + (req_write ? '0 : {1'b0, t_turn});
        end
    end

    amc_sequencer #(.TW(TW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .len   (len_q),
        .gap   (gap_q),
        .state (state),
        .tick  (tick),
        .done  (done)
    );

    // strobe window settings in package order
    assign on_v[STB_SEL]   = sel_on_q;  assign off_v[STB_SEL]  = sel_off_q;  assign en_v[STB_SEL]  = active;
    assign on_v[STB_ALAT]  = alat_on_q; assign off_v[STB_ALAT] = alat_off_q; assign en_v[STB_ALAT] = active;
    assign on_v[STB_RD]    = rd_on_q;   assign off_v[STB_RD]   = rd_off_q;   assign en_v[STB_RD]   = active && !wr_q;
    assign on_v[STB_WR]    = wr_on_q;   assign off_v[STB_WR]   = wr_off_q;   assign en_v[STB_WR]   = active && wr_q;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
        amc_strobe_win #(.TW(TW)) u_win (
            .en    (en_v[g]),
            .tick  (tick),
            .t_on  (on_v[g]),
            .t_off (off_v[g]),
            .act   (act_v[g])
        );
    end

    assign sel_n    = !act_v[STB_SEL];
    assign alat_n   = !act_v[STB_ALAT];
    assign rd_n     = !act_v[STB_RD];
    assign wr_n     = !act_v[STB_WR];
    assign dev_addr = active ? addr_q : '0;

    amc_bus_path #(.TW(TW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .is_wr         (wr_q),
        .mux           (mux_q),
        .x16           (x16_q),
        .tick          (tick),
        .t_addr_end_rd (alat_off_rd_q),
        .t_wdata       (wdat_q),
        .t_sample      (sample_q),
        .addr          (addr_q),
        .wdata         (wdata_q),
        .bus_in        (bus_in),
        .bus_out       (bus_out),
        .bus_oe        (bus_oe),
        .rd_data       (rd_data)
    );

    // R1: read and write enables never overlap
    assert_rd_wr_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R11: all strobes stay high and the bus is quiet while idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sel_n && alat_n && rd_n && wr_n && !bus_oe));

    // R10: the device address holds through an access
    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(dev_addr));

    // R3: done is followed by an idle cycle at the ports
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_amc_cycle_gen.sv
module test_amc_cycle_gen;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 4;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [TW-1:0] t_sel_on, t_sel_off_rd, t_sel_off_wr, t_alat_on, t_alat_off_rd, t_alat_off_wr;
    logic [TW-1:0] t_rd_on, t_rd_off, t_wr_on, t_wr_off, t_len_rd, t_len_wr;
    logic [TW-1:0] t_sample, t_wdata, t_turn, t_c2c;
    logic mode_mux, mode_x16;
    logic [DW-1:0] bus_in = '0;
    logic busy, done, sel_n, alat_n, rd_n, wr_n, bus_oe;
    logic [AW-1:0] dev_addr;
    logic [DW-1:0] bus_out, rd_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [DW-1:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amc_cycle_gen #(.TW(TW), .ADDR_W(AW), .DATA_W(DW)) i_amc_cycle_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .t_sel_on(t_sel_on), .t_sel_off_rd(t_sel_off_rd), .t_sel_off_wr(t_sel_off_wr),
        .t_alat_on(t_alat_on), .t_alat_off_rd(t_alat_off_rd), .t_alat_off_wr(t_alat_off_wr),
        .t_rd_on(t_rd_on), .t_rd_off(t_rd_off), .t_wr_on(t_wr_on), .t_wr_off(t_wr_off),
        .t_len_rd(t_len_rd), .t_len_wr(t_len_wr), .t_sample(t_sample), .t_wdata(t_wdata),
        .t_turn(t_turn), .t_c2c(t_c2c), .mode_mux(mode_mux), .mode_x16(mode_x16),
        .bus_in(bus_in), .busy(busy), .done(done), .sel_n(sel_n), .alat_n(alat_n),
        .rd_n(rd_n), .wr_n(wr_n), .dev_addr(dev_addr), .bus_out(bus_out),
        .bus_oe(bus_oe), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit win(int k, int on, int off);
        return (k >= on) && (k < off);
    endfunction

    function automatic logic [DW-1:0] pat(int k);
        return {8'(k) ^ 8'hC3, 8'(k * 5 + 17)};
    endfunction

    task automatic cfg_base(input int len);
        t_sel_on = 0; t_sel_off_rd = 4'(len); t_sel_off_wr = 4'(len);
        t_alat_on = 1; t_alat_off_rd = 3; t_alat_off_wr = 3;
        t_rd_on = 2; t_rd_off = 4'(len - 1); t_wr_on = 2; t_wr_off = 4'(len - 1);
        t_len_rd = 4'(len); t_len_wr = 4'(len); t_sample = 4'(len - 2); t_wdata = 3;
        t_turn = 0; t_c2c = 0; mode_mux = 1; mode_x16 = 1;
    endtask

    // self-inverse scramble: applying it twice restores the settings
    task automatic cfg_scramble();
        t_sel_on ^= 4'hA; t_sel_off_rd ^= 4'hA; t_sel_off_wr ^= 4'hA;
        t_alat_on ^= 4'hA; t_alat_off_rd ^= 4'hA; t_alat_off_wr ^= 4'hA;
        t_rd_on ^= 4'hA; t_rd_off ^= 4'hA; t_wr_on ^= 4'hA; t_wr_off ^= 4'hA;
        t_len_rd ^= 4'hA; t_len_wr ^= 4'hA; t_sample ^= 4'hA; t_wdata ^= 4'hA;
        t_turn ^= 4'hA; t_c2c ^= 4'hA; mode_mux = !mode_mux; mode_x16 = !mode_x16;
    endtask

    // one full access, called at a negedge while idle
    task automatic run_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input bit hold, input bit mutate);
        int s_on = t_sel_on, s_off = wr ? t_sel_off_wr : t_sel_off_rd;
        int a_on = t_alat_on, a_off = wr ? t_alat_off_wr : t_alat_off_rd, a_rd = t_alat_off_rd;
        int r_on = t_rd_on, r_off = t_rd_off, w_on = t_wr_on, w_off = t_wr_off;
        int len = wr ? t_len_wr : t_len_rd;
        int smp = t_sample, wdt = t_wdata;
        int gap = t_c2c + (wr ? 0 : t_turn);
        bit mux = mode_mux, x16 = mode_x16;
        logic [AW-1:0] ea = x16 ? (a >> 1) : a;
        logic [DW-1:0] wfit = x16 ? d : {8'h00, d[7:0]};
        if (len == 0) len = 1;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (hold) begin
            req_write = !wr; req_addr = ~a; req_wdata = ~d;
        end else begin
            req_valid = 0;
        end
        for (int k = 0; k < len; k++) begin
            bit aph = mux && (wr ? (k < wdt) : (k < a_rd));
            logic [DW-1:0] eo;
            bit eoe;
            if (mutate && k == 1) cfg_scramble();
            eoe = aph || wr;
            eo  = aph ? {8'h00, ea} : (wr ? wfit : '0);
            chk("R2 sel_n", 32'(sel_n), 32'(!win(k, s_on, s_off)));
            chk("R2 alat_n", 32'(alat_n), 32'(!win(k, a_on, a_off)));
            chk("R1 rd_n", 32'(rd_n), 32'(!(!wr && win(k, r_on, r_off))));
            chk("R1 wr_n", 32'(wr_n), 32'(!(wr && win(k, w_on, w_off))));
            chk("R3 busy", 32'(busy), 32'd1);
            chk("R3 done", 32'(done), 32'd0);
            chk(hold ? "R9 dev_addr" : (mutate ? "R10 dev_addr" : "R8 dev_addr"), 32'(dev_addr), 32'(ea));
            chk(mux ? "R6 bus_oe" : "R7 bus_oe", 32'(bus_oe), 32'(eoe));
            chk(mux ? "R6 bus_out" : "R7 bus_out", 32'(bus_out), 32'(eo));
            bus_in = pat(k);
            if (!wr && k == smp) exp_rd = x16 ? pat(k) : {8'h00, pat(k)[7:0]};
            @(negedge clk);
        end
        for (int g = 0; g < gap; g++) begin
            chk("R4 strobes", 32'({sel_n, alat_n, rd_n, wr_n}), 32'hF);
            chk("R4 busy", 32'(busy), 32'd1);
            chk("R4 done", 32'(done), 32'd0);
            chk("R4 bus_oe", 32'(bus_oe), 32'd0);
            @(negedge clk);
        end
        chk("R3 done end", 32'(done), 32'd1);
        chk("R3 busy end", 32'(busy), 32'd0);
        chk("R8 idle dev_addr", 32'(dev_addr), 32'd0);
        chk("R8 idle bus_out", 32'(bus_out), 32'd0);
        chk("R5 rd_data", 32'(rd_data), 32'(exp_rd));
        req_valid = 0;
        if (mutate) cfg_scramble();
        @(negedge clk);
        chk("R3 done single", 32'(done), 32'd0);
        chk("R9 no extra accept", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cfg_base(7);
        repeat (3) @(negedge clk);
        chk("R11 sel_n in reset", 32'(sel_n), 32'd1);
        chk("R11 strobes in reset", 32'({alat_n, rd_n, wr_n}), 32'h7);
        chk("R11 busy/done in reset", 32'({busy, done, bus_oe}), 32'd0);
        chk("R11 rd_data in reset", 32'(rd_data), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R11 after reset", 32'({busy, done, bus_oe, sel_n, wr_n}), 32'b00011);

        // strobe windows: every on/off pair for each strobe
        for (int s = 0; s < 4; s++)
            for (int on = 0; on < 7; on++)
                for (int off = 0; off < 8; off++) begin
                    cfg_base(7);
                    case (s)
                        0: begin t_sel_on = 4'(on); t_sel_off_rd = 4'(off); t_sel_off_wr = 4'((off + 3) % 8); end
                        1: begin t_alat_on = 4'(on); t_alat_off_rd = 4'((off + 5) % 8); t_alat_off_wr = 4'(off); end
                        2: begin t_rd_on = 4'(on); t_rd_off = 4'(off); end
                        default: begin t_wr_on = 4'(on); t_wr_off = 4'(off); end
                    endcase
                    mode_mux = 1'(on & 1);
                    mode_x16 = 1'(off & 1);
                    run_access(0, 8'(on * 16 + off), 16'(on * 4099 + off), 0, 0);
                    run_access(1, 8'(off * 16 + on + 1), 16'(off * 517 + on), 0, 0);
                end

        // sample tick sweep, including ticks past the end
        for (int x = 0; x < 2; x++)
            for (int m = 0; m < 2; m++)
                for (int smp = 0; smp < 10; smp++) begin
                    cfg_base(8);
                    mode_x16 = 1'(x); mode_mux = 1'(m); t_sample = 4'(smp);
                    run_access(0, 8'(smp + 40), 16'h0, 0, 0);
                    run_access(1, 8'(smp + 80), 16'hBEEF, 0, 0);
                end

        // multiplexed switch ticks for writes and reads
        for (int x = 0; x < 2; x++)
            for (int w = 0; w < 9; w++) begin
                cfg_base(8);
                mode_x16 = 1'(x); t_wdata = 4'(w); t_alat_off_rd = 4'(w);
                run_access(1, 8'(w * 3 + 7), 16'(16'h1234 + w), 0, 0);
                run_access(0, 8'(w * 5 + 2), 16'h0, 0, 0);
            end

        // gaps: turnaround after reads, cycle-to-cycle after all
        for (int tu = 0; tu < 4; tu++)
            for (int cc = 0; cc < 4; cc++)
                for (int wr = 0; wr < 2; wr++) begin
                    cfg_base(5);
                    t_turn = 4'(tu); t_c2c = 4'(cc);
                    run_access(1'(wr), 8'(tu * 4 + cc), 16'(tu * 97 + cc), 0, 0);
                end

        // length boundaries: 0 behaves as 1, and maximum length
        cfg_base(7);
        t_len_rd = 0; t_len_wr = 0; t_sample = 0; t_rd_off = 1; t_wr_off = 1;
        run_access(0, 8'h21, 16'h0, 0, 0);
        run_access(1, 8'h22, 16'h5555, 0, 0);
        t_len_rd = 1; t_len_wr = 1;
        run_access(0, 8'h23, 16'h0, 0, 0);
        run_access(1, 8'h24, 16'hAAAA, 0, 0);
        cfg_base(15);
        run_access(0, 8'hF3, 16'h0, 0, 0);
        run_access(1, 8'hF4, 16'h1357, 0, 0);

        // requests held during busy periods are ignored
        cfg_base(6);
        t_c2c = 2; t_turn = 1;
        run_access(0, 8'h5A, 16'h0, 1, 0);
        run_access(1, 8'hA5, 16'h7E7E, 1, 0);

        // configuration changes mid-access take effect next time
        cfg_base(9);
        t_c2c = 1;
        run_access(0, 8'h3C, 16'h0, 0, 1);
        run_access(1, 8'hC3, 16'h9A9A, 0, 1);
        mode_mux = 0; mode_x16 = 0;
        run_access(1, 8'h77, 16'hFEDC, 1, 1);
        run_access(0, 8'h78, 16'h0, 1, 1);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule